// File: doc/BRIEF.md
# Pixel-to-Lane Serializer (7:1, three data lanes plus clock lane)

The block accepts one parallel pixel per pixel period: 6 bits each of red, green and blue, plus horizontal sync, vertical sync and data-enable. It spreads these 21 bits across three data lanes of 7 bits each and shifts every lane out one bit per enabled fast-clock cycle, so the fast clock runs at seven times the pixel rate. A fourth lane carries a fixed clock pattern aligned to the data so that a receiver can frame each 7-bit group. The target pixel rate is 5 to 43 MHz; the fast clock and its enable come from outside.

A small sequencer tracks the slot position inside the 7-slot frame. Its states are `ST_IDLE` (nothing loaded since reset), `ST_HEAD` (slot 0 on the lanes), `ST_BODY` (slots 1 to 5, with a slot counter) and `ST_TAIL` (slot 6). On an enabled cycle the transitions are: `ST_IDLE`→`ST_HEAD` (first load), `ST_HEAD`→`ST_BODY`, `ST_BODY`→`ST_BODY` (counter step), `ST_BODY`→`ST_TAIL` (after slot 5), `ST_TAIL`→`ST_HEAD` (reload). Without the enable every state holds. The load pulse `pix_load` is high during the cycle whose rising edge captures the pixel inputs; upstream logic holds the pixel valid in that cycle. The colour lanes are serialized as presented whatever the data-enable level; no blanking value is substituted.

Top module: `pix_lane_serializer`

## Requirements
- R1: While reset is asserted, and after it until the first enabled cycle, all three data lanes and the clock lane output 0 and `pix_load` is 0.
- R2: `pix_load` is 1 exactly in the cycles where `step_en` is 1 and either no pixel has been loaded since reset or slot 6 is on the lanes; the pixel inputs are captured at the rising edge that ends that cycle.
- R3: Data lane 0 (`lane_dat[0]`) outputs in slots 0 to 6: green bit 0, then red bits 5, 4, 3, 2, 1, 0.
- R4: Data lane 1 (`lane_dat[1]`) outputs in slots 0 to 6: blue bit 1, blue bit 0, then green bits 5, 4, 3, 2, 1.
- R5: Data lane 2 (`lane_dat[2]`) outputs in slots 0 to 6: data-enable, vertical sync, horizontal sync, then blue bits 5, 4, 3, 2.
- R6: The clock lane outputs 1,1,0,0,0,1,1 in slots 0 to 6, in the same cycles as the data lane slots.
- R7: A rising edge with `step_en` low changes no lane output and does not advance the slot position.
- R8: A new pixel is loaded once every 7 enabled cycles, all four lanes together; pixel input changes at any other edge have no effect on the lanes.
- R9: With data-enable low the colour bits are still serialized exactly as presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (7x pixel) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Fast-clock enable; each enabled edge advances one slot |
| red | input | 6 | Red channel |
| grn | input | 6 | Green channel |
| blu | input | 6 | Blue channel |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data enable |
| pix_load | output | 1 | High in the cycle whose edge captures a new pixel |
| lane_dat | output | 3 | Serial data lanes, bit i is lane i |
| lane_clk | output | 1 | Clock lane pattern |

## Verification
The hardest case is an enable gap that falls exactly on the reload boundary: the sequencer sits in `ST_TAIL` with `step_en` low while the pixel inputs keep changing, and only the later enabled edge may capture them. The stimulus reaches it by running long stretches with a randomly gated enable and inputs that change on every cycle, so gaps land on every slot including slot 6 and the first slot after reset, while a queue-based model predicts each lane bit and the load pulse every cycle.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

    localparam int CHAN_BITS = 6;
    localparam int SLOTS     = 7;
    localparam int DLANES    = 3;

    typedef logic [SLOTS-1:0]             lane_word_t;
    typedef logic [DLANES-1:0][SLOTS-1:0] lane_bank_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } seq_state_t;

    // Word bit SLOTS-1 goes out first.
    function automatic lane_bank_t pack_pixel(
        input logic [CHAN_BITS-1:0] r,
        input logic [CHAN_BITS-1:0] g,
        input logic [CHAN_BITS-1:0] b,
        input logic                 hs,
        input logic                 vs,
        input logic                 de
    );
        lane_bank_t bank;
        bank[0] = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
        bank[1] = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
        bank[2] = {de, vs, hs, b[5], b[4], b[3], b[2]};
        return bank;
    endfunction

endpackage

// File: rtl/ser_sequencer.sv
module ser_sequencer
    import pix_ser_pkg::*;
#(
    parameter int NSLOT = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en,
    output logic       load_now,
    output logic       shift_now,
    output seq_state_t state_q
);

    localparam int PW = $clog2(NSLOT);
    localparam logic [PW-1:0] LAST_BODY = PW'(NSLOT - 2);

    seq_state_t    state_d;
    logic [PW-1:0] pos_q, pos_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (step_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_HEAD;
                    pos_d   = '0;
                end
                ST_HEAD: begin
                    state_d = ST_BODY;
                    pos_d   = PW'(1);
                end
                ST_BODY: begin
                    pos_d = pos_q + PW'(1);
                    if (pos_q == LAST_BODY) state_d = ST_TAIL;
                end
                ST_TAIL: begin
                    state_d = ST_HEAD;
                    pos_d   = '0;
                end
                default: begin
                    state_d = ST_IDLE;
                    pos_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        load_now  = 1'b0;
        shift_now = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TAIL: load_now  = step_en;
            ST_HEAD, ST_BODY: shift_now = step_en;
            default: begin
                load_now  = 1'b0;
                shift_now = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] word,
    output logic         bit_out
);

    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= word;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign bit_out = sreg[W-1];

endmodule

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer
    import pix_ser_pkg::*;
#(
    parameter int         NSLOT       = SLOTS,
    parameter int         NLANE       = DLANES,
    parameter logic [6:0] CLK_PATTERN = 7'b1100011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [CHAN_BITS-1:0] red,
    input  logic [CHAN_BITS-1:0] grn,
    input  logic [CHAN_BITS-1:0] blu,
    input  logic                 hsync,
    input  logic                 vsync,
    input  logic                 den,
    output logic                 pix_load,
    output logic [NLANE-1:0]     lane_dat,
    output logic                 lane_clk
);

    logic       load_now;
    logic       shift_now;
    seq_state_t seq_state;
    lane_bank_t bank;

    ser_sequencer #(.NSLOT(NSLOT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .load_now  (load_now),
        .shift_now (shift_now),
        .state_q   (seq_state)
    );

    assign bank     = pack_pixel(red, grn, blu, hsync, vsync, den);
    assign pix_load = load_now;

    for (genvar li = 0; li < NLANE; li++) begin : g_data_lane
        lane_shifter #(.W(NSLOT)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_now),
            .shift   (shift_now),
            .word    (bank[li]),
            .bit_out (lane_dat[li])
        );
    end

    lane_shifter #(.W(NSLOT)) u_clk_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_now),
        .shift   (shift_now),
        .word    (CLK_PATTERN),
        .bit_out (lane_clk)
    );

endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
    parameter int         NSLOT       = 7,
    parameter int         NLANE       = 3,
    parameter logic [6:0] CLK_PATTERN = 7'b1100011
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             pix_load,
    input logic [NLANE-1:0] lane_dat,
    input logic             lane_clk
);

    localparam int CW = $clog2(NSLOT);

    logic          seen;
    logic [CW-1:0] slot_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen   <= 1'b0;
            slot_c <= '0;
        end else if (pix_load) begin
            seen   <= 1'b1;
            slot_c <= '0;
        end else if (step_en && seen) begin
            slot_c <= slot_c + CW'(1);
        end
    end

    // R1
    quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (lane_dat == '0 && !lane_clk));

    // R2
    load_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_load |-> step_en);

    // R8
    load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_load |-> (!seen || slot_c == CW'(NSLOT - 1)));

    // R8
    reload_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && step_en && slot_c == CW'(NSLOT - 1)) |-> pix_load);

    // R6
    clk_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (lane_clk == CLK_PATTERN[(NSLOT - 1) - int'(slot_c)]));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_en) |-> ($stable(lane_dat) && $stable(lane_clk)));

endmodule

bind pix_lane_serializer ser_checker #(
    .NSLOT       (NSLOT),
    .NLANE       (NLANE),
    .CLK_PATTERN (CLK_PATTERN)
) u_ser_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .pix_load (pix_load),
    .lane_dat (lane_dat),
    .lane_clk (lane_clk)
);

// File: tb/test_pix_lane_serializer.sv
module test_pix_lane_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic [5:0] red = '0, grn = '0, blu = '0;
    logic       hsync = 1'b0, vsync = 1'b0, den = 1'b0;
    logic       pix_load;
    logic [2:0] lane_dat;
    logic       lane_clk;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // reference model state
    int pos = -1;
    bit q0[$], q1[$], q2[$], qc[$];
    string ph = "R1";

    always #5 clk = ~clk;

    pix_lane_serializer i_pix_lane_serializer (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .red      (red),
        .grn      (grn),
        .blu      (blu),
        .hsync    (hsync),
        .vsync    (vsync),
        .den      (den),
        .pix_load (pix_load),
        .lane_dat (lane_dat),
        .lane_clk (lane_clk)
    );

    task automatic check_bit(string tag, logic got, logic exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s [%s] got %b expected %b at %0t", tag, ph, got, exp, $time);
        end
    endtask

    function automatic bit front(ref bit q[$]);
        return (q.size() > 0) ? q[0] : 1'b0;
    endfunction

    task automatic compare_all();
        bit exp_load;
        exp_load = step_en && (pos == -1 || pos == 6);
        check_bit("R2 pix_load", pix_load, exp_load);
        check_bit("R3 lane0", lane_dat[0], front(q0));
        check_bit("R4 lane1", lane_dat[1], front(q1));
        check_bit("R5 lane2", lane_dat[2], front(q2));
        check_bit("R6 clk lane", lane_clk, front(qc));
    endtask

    task automatic model_edge();
        if (!step_en) return;
        if (pos == -1 || pos == 6) begin
            q0.delete(); q1.delete(); q2.delete(); qc.delete();
            q0.push_back(grn[0]);
            for (int k = 5; k >= 0; k--) q0.push_back(red[k]);
            q1.push_back(blu[1]);
            q1.push_back(blu[0]);
            for (int k = 5; k >= 1; k--) q1.push_back(grn[k]);
            q2.push_back(den);
            q2.push_back(vsync);
            q2.push_back(hsync);
            for (int k = 5; k >= 2; k--) q2.push_back(blu[k]);
            qc = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            pos = 0;
        end else begin
            void'(q0.pop_front());
            void'(q1.pop_front());
            void'(q2.pop_front());
            void'(qc.pop_front());
            pos++;
        end
    endtask

    // mode: 0 random, 1 fixed value; de_mode: 0 random, 1 forced low
    task automatic run_phase(int n, int en_pct, bit fixed, logic [17:0] rgb, bit de_low);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            step_en = (($urandom % 100) < en_pct);
            if (fixed) {blu, grn, red} = rgb;
            else {blu, grn, red} = 18'($urandom);
            hsync = $urandom % 2;
            vsync = $urandom % 2;
            den   = de_low ? 1'b0 : 1'($urandom % 2);
            #1;
            compare_all();
            @(posedge clk);
            model_edge();
        end
    endtask

    initial begin
        // R1: during reset
        repeat (3) @(negedge clk);
        check_bit("R1 reset lane", |lane_dat, 1'b0);
        check_bit("R1 reset clk", lane_clk, 1'b0);
        check_bit("R1 reset load", pix_load, 1'b0);
        rst_n = 1'b1;
        ph = "R1 idle";
        run_phase(4, 0, 1'b0, '0, 1'b0);
        ph = "R8 steady";
        run_phase(140, 100, 1'b0, '0, 1'b0);
        ph = "R7 gated";
        run_phase(2000, 50, 1'b0, '0, 1'b0);
        ph = "R7 sparse";
        run_phase(1000, 15, 1'b0, '0, 1'b0);
        ph = "R9 blank";
        run_phase(700, 80, 1'b0, '0, 1'b1);
        ph = "R3 ones";
        run_phase(70, 100, 1'b1, 18'h3FFFF, 1'b0);
        ph = "R4 alt";
        run_phase(70, 100, 1'b1, 18'h2AAAA, 1'b0);
        ph = "R5 walk";
        for (int b = 0; b < 18; b++) run_phase(14, 100, 1'b1, 18'(1) << b, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule